// File: doc/BRIEF.md
# Image Sensor Row Readout Sequencer

This block sequences the readout of one sensor row at a time in synchronous shutter mode. A row-start strobe loads a starting row address and clears the line counter. Each row-clock pulse selects the next row. When the row clock is released, a row-blanking interval begins. Its length is 35 times a multiplier of 4, 8, 16 or 32, chosen by a 2-bit granularity code. Inside the blanking interval the block issues one pulse to sample the signal level and a later pulse to sample the reset level.

When blanking ends, a column-sync request is raised. The request fires as a one-cycle column-sync pulse once no line readout is active. The pulse opens a pixel-valid window, and a pixel counter runs through the programmed pixels per row. A copy of the valid window and the pixel index follows five running cycles later and marks when pixel data is present. While the row clock is held high, all blanking, readout and delay state stays frozen. A last-line flag reports when the line counter equals the programmed line count.

Top module: `row_readout_seq`

## Requirements
- R1: A row-clock falling edge is a cycle with row_clk_i low after a cycle with it high. The edge starts blanking, and blank_o is high for exactly 35 << (cfg_gran_i + 2) running cycles, which is 140, 280, 560 or 1120 for codes 0 to 3. The code is taken at the edge. A new edge during blanking restarts the interval.
- R2: While row_clk_i is high, the blanking state, the pending request, pixel-valid, the pixel counter and the output delay line all hold their values, and col_sync_o stays low.
- R3: samp_sig_o is high for the single blanking cycle with elapsed count 4, and samp_rst_o for the one with elapsed count 20. The first blanking cycle has elapsed count 0.
- R4: At the end of blanking a column-sync request is set. In the next running cycle with no readout active, col_sync_o pulses for one cycle, and pix_valid_o rises with it while pix_cnt_o is 0.
- R5: While pix_valid_o is high, pix_cnt_o rises by one per running cycle. pix_valid_o drops in the cycle the count reaches cfg_pix_per_row_i, so it stays high for cfg_pix_per_row_i cycles (one cycle if that value is 0).
- R6: A column-sync request that becomes pending while pix_valid_o is high is held without effect and fires only after pix_valid_o has dropped.
- R7: data_valid_o and data_idx_o equal pix_valid_o and pix_cnt_o as they were five running cycles earlier. data_valid_o therefore rises five cycles after col_sync_o.
- R8: While row_start_i is high, line_cnt_o becomes 0 and row_addr_o is loaded from cfg_row_ptr_i. Otherwise each row-clock falling edge adds one to both, wrapping at their widths.
- R9: last_line_o is high exactly when line_cnt_o equals cfg_lines_i. It therefore holds for one line period, until the next row-clock falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_start_i | input | 1 | Row-start strobe |
| row_clk_i | input | 1 | Row clock; high freezes the sequencer, falling edge starts a line |
| cfg_row_ptr_i | input | ROW_W | Starting row address |
| cfg_pix_per_row_i | input | PIX_W | Pixels per row |
| cfg_lines_i | input | LINE_W | Lines per frame, compared with the line counter |
| cfg_gran_i | input | 2 | Blanking granularity code |
| blank_o | output | 1 | Row-blanking interval active |
| samp_sig_o | output | 1 | Signal-level sample pulse |
| samp_rst_o | output | 1 | Reset-level sample pulse |
| col_sync_o | output | 1 | Column-sync pulse |
| pix_valid_o | output | 1 | Pixel readout window |
| pix_cnt_o | output | PIX_W | Pixel counter |
| line_cnt_o | output | LINE_W | Line counter |
| row_addr_o | output | ROW_W | Current row address |
| last_line_o | output | 1 | Last line of the frame |
| data_valid_o | output | 1 | Pixel data present, delayed window |
| data_idx_o | output | PIX_W | Index of the pixel whose data is present |

## Verification
The end of blanking for a new line can fall in the same cycle as the final pixel of the previous line's readout. This decides whether the column-sync request waits one more cycle or fires at once. The bench provokes it with rows of 200 pixels and a second row-clock pulse released at a sweep of six offsets after the first column sync, so the 140-cycle blanking ends just before, at and after the last pixel. Every cycle it compares col_sync_o, pix_valid_o and the delayed data outputs with a behavioural model that tracks the pending request on its own.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    localparam int unsigned BLANK_BASE = 35;
    localparam int unsigned BLANK_MAX  = BLANK_BASE * 32;

    // Blanking length in cycles for a granularity code: 35 * (4 << code)
    function automatic int unsigned blank_cycles(input logic [1:0] code);
        return BLANK_BASE << (32'(code) + 32'd2);
    endfunction
endpackage

// File: rtl/rrs_blank_timer.sv
module rrs_blank_timer
    import rrs_pkg::*;
#(
    parameter int unsigned SIG_AT = 4,
    parameter int unsigned RST_AT = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       start_i,
    input  logic [1:0] gran_i,
    output logic       blank_o,
    output logic       done_o,
    output logic       samp_sig_o,
    output logic       samp_rst_o
);
    localparam int unsigned BW = $clog2(BLANK_MAX);

    typedef struct packed {
        logic          blank;
        logic [1:0]    gran;
        logic [BW-1:0] el;
    } tmr_t;

    tmr_t          st_d, st_q;
    logic [BW-1:0] last_el;
    logic          at_end;

    always_comb begin
        last_el = BW'(blank_cycles(st_q.gran) - 32'd1);
        at_end  = st_q.blank && (st_q.el == last_el);
        st_d    = st_q;
        if (run_i) begin
            if (start_i) begin
                st_d.blank = 1'b1;
                st_d.gran  = gran_i;
                st_d.el    = '0;
            end else if (st_q.blank) begin
                if (at_end) st_d.blank = 1'b0;
                else        st_d.el    = st_q.el + 1'b1;
            end
        end
        done_o     = run_i && !start_i && at_end;
        blank_o    = st_q.blank;
        samp_sig_o = st_q.blank && (st_q.el == BW'(SIG_AT));
        samp_rst_o = st_q.blank && (st_q.el == BW'(RST_AT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: no blanking progress while the row clock is held high
    a_r2_timer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> ($stable(st_q.el) && $stable(st_q.blank)));
    // R1: blanking closes after its final counted cycle
    a_r1_blank_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o) |=> !blank_o);
    // R3: the two sample pulses never coincide
    a_r3_sample_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(samp_sig_o && samp_rst_o));
endmodule

// File: rtl/rrs_line_track.sv
module rrs_line_track #(
    parameter int unsigned LINE_W = 10,
    parameter int unsigned ROW_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_start_i,
    input  logic              fall_i,
    input  logic [ROW_W-1:0]  ptr_i,
    input  logic [LINE_W-1:0] lines_i,
    output logic [LINE_W-1:0] line_o,
    output logic [ROW_W-1:0]  addr_o,
    output logic              last_o
);
    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [ROW_W-1:0]  addr;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (row_start_i) begin
            st_d.line = '0;
            st_d.addr = ptr_i;
        end else if (fall_i) begin
            st_d.line = st_q.line + 1'b1;
            st_d.addr = st_q.addr + 1'b1;
        end
        line_o = st_q.line;
        addr_o = st_q.addr;
        last_o = (st_q.line == lines_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: row start clears the line counter and loads the row address
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        row_start_i |=> (line_o == '0));
    a_r8_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        row_start_i |=> (addr_o == $past(ptr_i)));
endmodule

// File: rtl/rrs_col_readout.sv
module rrs_col_readout #(
    parameter int unsigned PIX_W = 11,
    parameter int unsigned DELAY = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             req_i,
    input  logic [PIX_W-1:0] ppr_i,
    output logic             col_sync_o,
    output logic             pv_o,
    output logic [PIX_W-1:0] pcnt_o,
    output logic             dv_o,
    output logic [PIX_W-1:0] didx_o
);
    typedef struct packed {
        logic                        pend;
        logic                        cs;
        logic                        pv;
        logic [PIX_W-1:0]            pcnt;
        logic [DELAY-1:0]            dv;
        logic [DELAY-1:0][PIX_W-1:0] idx;
    } rd_t;

    rd_t          st_d, st_q;
    logic         fire;
    logic [PIX_W:0] next_cnt;

    always_comb begin
        st_d     = st_q;
        st_d.cs  = 1'b0;
        fire     = run_i && st_q.pend && !st_q.pv;
        next_cnt = {1'b0, st_q.pcnt} + 1'b1;
        if (run_i) begin
            st_d.pend = (st_q.pend && !fire) || req_i;
            st_d.cs   = fire;
            for (int i = DELAY - 1; i > 0; i--) begin
                st_d.dv[i]  = st_q.dv[i-1];
                st_d.idx[i] = st_q.idx[i-1];
            end
            st_d.dv[0]  = st_q.pv;
            st_d.idx[0] = st_q.pcnt;
            if (fire) begin
                st_d.pv   = 1'b1;
                st_d.pcnt = '0;
            end else if (st_q.pv) begin
                st_d.pcnt = next_cnt[PIX_W-1:0];
                if (next_cnt >= {1'b0, ppr_i}) st_d.pv = 1'b0;
            end
        end
        col_sync_o = st_q.cs;
        pv_o       = st_q.pv;
        pcnt_o     = st_q.pcnt;
        dv_o       = st_q.dv[DELAY-1];
        didx_o     = st_q.idx[DELAY-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: readout state holds and no sync is issued while frozen
    a_r2_readout_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> ($stable(st_q.pv) && $stable(st_q.pcnt) && !st_q.cs));
    // R5: counter stays below the row length inside the window
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_o && ppr_i != '0) |-> (pcnt_o < ppr_i));
    // R6: no sync pulse in the middle of an active line
    a_r6_no_resync: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_o && pcnt_o != '0) |-> !col_sync_o);
    // R4: the window opens together with the sync pulse
    a_r4_sync_opens: assert property (@(posedge clk) disable iff (!rst_n)
        col_sync_o |-> (pv_o && pcnt_o == '0));
endmodule

// File: rtl/row_readout_seq.sv
module row_readout_seq
    import rrs_pkg::*;
#(
    parameter int unsigned PIX_W  = 11,
    parameter int unsigned LINE_W = 10,
    parameter int unsigned ROW_W  = 10,
    parameter int unsigned DELAY  = 5,
    parameter int unsigned SIG_AT = 4,
    parameter int unsigned RST_AT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_start_i,
    input  logic              row_clk_i,
    input  logic [ROW_W-1:0]  cfg_row_ptr_i,
    input  logic [PIX_W-1:0]  cfg_pix_per_row_i,
    input  logic [LINE_W-1:0] cfg_lines_i,
    input  logic [1:0]        cfg_gran_i,
    output logic              blank_o,
    output logic              samp_sig_o,
    output logic              samp_rst_o,
    output logic              col_sync_o,
    output logic              pix_valid_o,
    output logic [PIX_W-1:0]  pix_cnt_o,
    output logic [LINE_W-1:0] line_cnt_o,
    output logic [ROW_W-1:0]  row_addr_o,
    output logic              last_line_o,
    output logic              data_valid_o,
    output logic [PIX_W-1:0]  data_idx_o
);
    logic rclk_d, rclk_q;
    logic fall, run, blank_done;

    always_comb begin
        rclk_d = row_clk_i;
        run    = !row_clk_i;
        fall   = rclk_q && !row_clk_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rclk_q <= 1'b0;
        else        rclk_q <= rclk_d;
    end

    rrs_blank_timer #(.SIG_AT(SIG_AT), .RST_AT(RST_AT)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .start_i    (fall),
        .gran_i     (cfg_gran_i),
        .blank_o    (blank_o),
        .done_o     (blank_done),
        .samp_sig_o (samp_sig_o),
        .samp_rst_o (samp_rst_o)
    );

    rrs_col_readout #(.PIX_W(PIX_W), .DELAY(DELAY)) u_readout (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .req_i      (blank_done),
        .ppr_i      (cfg_pix_per_row_i),
        .col_sync_o (col_sync_o),
        .pv_o       (pix_valid_o),
        .pcnt_o     (pix_cnt_o),
        .dv_o       (data_valid_o),
        .didx_o     (data_idx_o)
    );

    rrs_line_track #(.LINE_W(LINE_W), .ROW_W(ROW_W)) u_lines (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_start_i (row_start_i),
        .fall_i      (fall),
        .ptr_i       (cfg_row_ptr_i),
        .lines_i     (cfg_lines_i),
        .line_o      (line_cnt_o),
        .addr_o      (row_addr_o),
        .last_o      (last_line_o)
    );

    // R1: a row-clock release always starts blanking
    a_r1_release_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(row_clk_i) && !row_clk_i) |=> blank_o);
    // R9: flag tracks the line comparison across a release
    a_r9_last_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (last_line_o && fall && !row_start_i && $stable(cfg_lines_i)) |=> !last_line_o);
endmodule

// File: tb/row_readout_seq_bench.sv
module row_readout_seq_bench;
    localparam int PIX_W = 11, LINE_W = 10, ROW_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic row_start = 1'b0, row_clk = 1'b0;
    logic [ROW_W-1:0]  cfg_ptr = '0;
    logic [PIX_W-1:0]  cfg_ppr = 11'd10;
    logic [LINE_W-1:0] cfg_lines = 10'd3;
    logic [1:0]        cfg_gran = 2'd0;
    logic blank, s_sig, s_rst, cs, pv, last, dv;
    logic [PIX_W-1:0]  pcnt, didx;
    logic [LINE_W-1:0] line;
    logic [ROW_W-1:0]  addr;

    always #5 clk = ~clk;

    row_readout_seq u_row_readout_seq (
        .clk(clk), .rst_n(rst_n), .row_start_i(row_start), .row_clk_i(row_clk),
        .cfg_row_ptr_i(cfg_ptr), .cfg_pix_per_row_i(cfg_ppr), .cfg_lines_i(cfg_lines),
        .cfg_gran_i(cfg_gran), .blank_o(blank), .samp_sig_o(s_sig), .samp_rst_o(s_rst),
        .col_sync_o(cs), .pix_valid_o(pv), .pix_cnt_o(pcnt), .line_cnt_o(line),
        .row_addr_o(addr), .last_line_o(last), .data_valid_o(dv), .data_idx_o(didx)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done_flag = 0, compare_on = 0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_line, m_addr, m_el, m_len, m_pcnt;
    bit m_prev, m_blank, m_pend, m_pv, m_cs;
    int dq[$];

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_line = 0; m_addr = 0; m_el = 0; m_len = 140; m_pcnt = 0;
            m_prev = 0; m_blank = 0; m_pend = 0; m_pv = 0; m_cs = 0;
            dq.delete();
            repeat (5) dq.push_back(0);
        end else begin
            bit fall, run, o_pv, o_pend, ended, go;
            int o_pcnt, junk;
            fall = m_prev && !row_clk;
            run  = !row_clk;
            if (row_start) begin
                m_line = 0; m_addr = int'(cfg_ptr);
            end else if (fall) begin
                m_line = (m_line + 1) % (1 << LINE_W);
                m_addr = (m_addr + 1) % (1 << ROW_W);
            end
            m_cs = 0;
            if (run) begin
                o_pv = m_pv; o_pend = m_pend; o_pcnt = m_pcnt; ended = 0;
                if (fall) begin
                    m_blank = 1; m_el = 0; m_len = 35 << (int'(cfg_gran) + 2);
                end else if (m_blank) begin
                    if (m_el == m_len - 1) begin m_blank = 0; ended = 1; end
                    else m_el++;
                end
                go = o_pend && !o_pv;
                m_pend = (o_pend && !go) || ended;
                dq.push_back(o_pv ? o_pcnt + 1 : 0);
                junk = dq.pop_front();
                if (go) begin m_cs = 1; m_pv = 1; m_pcnt = 0; end
                else if (o_pv) begin
                    m_pcnt++;
                    if (m_pcnt >= int'(cfg_ppr)) m_pv = 0;
                end
            end
            m_prev = row_clk;
        end
    end

    // Per-cycle comparison and explicit delay check (R7)
    int last_cs_cyc = -100;
    bit prev_dv = 0;
    always @(negedge clk) begin
        if (rst_n && compare_on && !done_flag) begin
            check("R1 blank", blank, m_blank);
            check("R3 signal sample", s_sig, m_blank && m_el == 4);
            check("R3 reset sample", s_rst, m_blank && m_el == 20);
            check("R4 col sync", cs, m_cs);
            check("R5 pixel valid", pv, m_pv);
            check("R5 pixel count", pcnt, m_pcnt);
            check("R8 line count", line, m_line);
            check("R8 row address", addr, m_addr);
            check("R9 last line", last, m_line == int'(cfg_lines));
            check("R7 data valid", dv, dq[0] != 0);
            if (dq[0] != 0) check("R7 data index", didx, dq[0] - 1);
            if (cs) last_cs_cyc = cyc;
            if (dv && !prev_dv && !row_clk) check("R7 five-cycle lag", cyc - last_cs_cyc, 5);
            prev_dv = dv;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_rclk(input int w);
        row_clk = 1'b1; tick(w); row_clk = 1'b0;
    endtask

    task automatic wait_cs();
        int guard = 0;
        while (!cs && guard < 5000) begin tick(1); guard++; end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int len, w;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // Reset state
        check("R1 reset blank", blank, 0);
        check("R5 reset valid", pv, 0);
        check("R8 reset line", line, 0);
        check("R7 reset data valid", dv, 0);
        compare_on = 1;

        // R1: blanking length per granularity code, plus R3/R4/R5/R7 via model
        for (int g = 0; g < 4; g++) begin
            cfg_gran = 2'(g);
            pulse_rclk(1);
            while (!blank) tick(1);
            len = 0;
            while (blank) begin len++; tick(1); end
            check("R1 blank length", len, 35 << (g + 2));
            tick(40);
        end

        // R8/R9: row start, line stepping and last-line flag
        cfg_gran = 2'd0; cfg_ptr = 10'd37; cfg_lines = 10'd3;
        row_start = 1'b1; tick(3); row_start = 1'b0;
        check("R8 start clears line", line, 0);
        check("R8 start loads row", addr, 37);
        for (int k = 0; k < 3; k++) begin pulse_rclk(2); tick(180); end
        check("R9 last line high", last, 1);
        check("R8 row advanced", addr, 40);
        pulse_rclk(2); tick(1);
        check("R9 last line dropped", last, 0);
        tick(200);

        // R2: freeze in the middle of a readout stretches the window
        cfg_ppr = 11'd50;
        pulse_rclk(1); wait_cs();
        tick(10);
        w = 0;
        row_clk = 1'b1; tick(7); row_clk = 1'b0;
        while (pv) begin w++; tick(1); end
        check("R2 frozen window length", w + 10 + 7, 50 + 7);
        tick(300);

        // R6: blanking end near the final pixel, swept over offsets
        cfg_ppr = 11'd200;
        for (int d = 0; d < 6; d++) begin
            int ncs;
            pulse_rclk(1); wait_cs();
            tick(55 + d);
            pulse_rclk(1);
            ncs = 0;
            for (int t = 0; t < 600; t++) begin
                tick(1);
                if (cs) begin
                    ncs++;
                    check("R6 deferred sync starts fresh line", pcnt, 0);
                end
            end
            check("R6 exactly one deferred sync", ncs, 1);
            tick(50);
        end

        compare_on = 0;
        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule